// File: doc/BRIEF.md
# Split 32-bit Interval Timer with Compare Bank

This block is a memory-mapped timer built from two 32-bit count-up halves, a low half and a high half. Each half has its own counter, its own period register, its own two-bit run mode (off, single-shot or repeating) and its own interrupt pulse. When a running half's count equals its period, it pulses its interrupt and starts again from zero. In single-shot mode the half also clears its own run mode, so it stops after one event.

A bank of compare registers watches the low counter. Each register has its own pulse output, and an OR of all of them drives a shared compare line. Software uses these registers to schedule events against a free-running low counter: it reads the count, adds a delta with wrapping 32-bit addition, and writes the sum into a compare slot.

A global control word selects the operating mode and releases each half from reset. Only the split (unchained) 32-bit mode counts. The other mode codes can be written and read back, but they keep both counters frozen.

Top module: `split_timer`

## Requirements
- R1: Registers sit at byte offsets 0x00 (read-only ID), 0x10 low count, 0x14 high count, 0x18 low period, 0x1C high period, 0x20 run control, 0x24 global control, 0x28 watchdog word, and 0x60 + 4*i for compare slot i. Read data is registered and shows the value the addressed register held at the clock edge that samples the address. The watchdog word, unmapped offsets and unaligned offsets read as zero. At reset both periods are all ones and every other register is zero.
- R2: The run control word holds the low half's run mode in bits 7:6 and the high half's in bits 23:22. All other bits read as zero. Mode code 0 is off, 1 is single-shot and 2 is repeating.
- R3: Global control bits 3:2 select the timer mode. A half counts only when this field is 1. With any other value the counters keep their values.
- R4: Global control bit 0 releases the low half and bit 1 releases the high half. While its bit is 0, a half's counter is forced to zero and writes to that counter are ignored.
- R5: In repeating mode, a half that starts from count V with period P pulses its interrupt for one cycle P-V+1 edges after the enabling write. It then pulses again every P+1 edges.
- R6: In single-shot mode the half pulses once, its run-mode field reads back as 0, its counter rests at 0, and no further pulse follows.
- R7: With the period set to all ones, the counter wraps from 0xFFFFFFFF to 0 and pulses its interrupt on that wrap.
- R8: A write to a counter register takes effect at the next edge, whether or not the half is running.
- R9: Compare slot i pulses cmp_irq[i] for exactly one clock. The pulse comes on the edge after a running low counter holds that slot's value. Only matching slots pulse.
- R10: A compare value formed with wrapping 32-bit addition across zero matches after the counter wraps.
- R11: cmp_any is high exactly when any cmp_irq bit is high.
- R12: Run-mode code 3 is reserved and acts as off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for bus_addr |
| irq_lo | output | 1 | Low half period/wrap pulse |
| irq_hi | output | 1 | High half period/wrap pulse |
| cmp_irq | output | 8 | One pulse line per compare slot |
| cmp_any | output | 1 | OR of all compare pulses |

## Verification
If a write arms a half at edge E with count V, the half's interrupt is due at edge E+P-V+1. A compare slot holding C is due at edge E+C-V+1. Read data is due one edge after the address is presented. The bench drives and samples on falling edges and counts the edges between the arming write and the first high sample. It compares that count with the figure worked out from these formulas. Reads follow writes with no idle cycle between them, so a counter read lands on a known count.

// File: rtl/split_timer_pkg.sv
package split_timer_pkg;

  typedef enum logic [1:0] {
    RUN_OFF  = 2'd0,
    RUN_ONCE = 2'd1,
    RUN_LOOP = 2'd2,
    RUN_RSVD = 2'd3
  } run_mode_e;

  localparam logic [1:0] TMODE_SPLIT = 2'd1;

  localparam logic [7:0] OFS_ID     = 8'h00;
  localparam logic [7:0] OFS_CNT_LO = 8'h10;
  localparam logic [7:0] OFS_CNT_HI = 8'h14;
  localparam logic [7:0] OFS_PRD_LO = 8'h18;
  localparam logic [7:0] OFS_PRD_HI = 8'h1C;
  localparam logic [7:0] OFS_RUN    = 8'h20;
  localparam logic [7:0] OFS_GLOBAL = 8'h24;
  localparam logic [7:0] OFS_WDOG   = 8'h28;
  localparam logic [7:0] OFS_CMP0   = 8'h60;

  localparam int LO_MODE_LSB = 6;
  localparam int HI_MODE_LSB = 22;

endpackage

// File: rtl/split_timer_half.sv
module split_timer_half
  import split_timer_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rel,
  input  logic          tm_ok,
  input  logic          cnt_we,
  input  logic          prd_we,
  input  logic          mode_we,
  input  logic [DW-1:0] wdata,
  input  logic [1:0]    mode_wdata,
  output logic [DW-1:0] cnt,
  output logic [DW-1:0] prd,
  output logic [1:0]    mode,
  output logic          irq,
  output logic          running
);

  logic [DW-1:0] cnt_q;
  logic [DW-1:0] prd_q;
  run_mode_e     mode_q;
  logic          irq_q;
  logic          mode_live;
  logic          hit;

  always_comb begin
    mode_live = (mode_q == RUN_ONCE) || (mode_q == RUN_LOOP);
    running   = rel && tm_ok && mode_live && !cnt_we;
    hit       = running && (cnt_q == prd_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      prd_q  <= '1;
      mode_q <= RUN_OFF;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= hit;
      if (prd_we) prd_q <= wdata;
      if (mode_we) mode_q <= run_mode_e'(mode_wdata);
      else if (hit && mode_q == RUN_ONCE) mode_q <= RUN_OFF;
      if (!rel) cnt_q <= '0;
      else if (cnt_we) cnt_q <= wdata;
      else if (hit) cnt_q <= '0;
      else if (running) cnt_q <= cnt_q + DW'(1);
    end
  end

  assign cnt  = cnt_q;
  assign prd  = prd_q;
  assign mode = mode_q;
  assign irq  = irq_q;

endmodule

// File: rtl/split_timer_cmp.sv
module split_timer_cmp #(
  parameter int DW = 32,
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [IW-1:0]        idx,
  input  logic [DW-1:0]        wdata,
  input  logic [DW-1:0]        cnt,
  input  logic                 running,
  output logic [N-1:0][DW-1:0] vals,
  output logic [N-1:0]         pulse,
  output logic                 any
);

  logic [DW-1:0] slot_q [N];
  logic [N-1:0]  hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) slot_q[i] <= '0;
    end else begin
      for (int i = 0; i < N; i++)
        if (we && idx == IW'(i)) slot_q[i] <= wdata;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_slot
    assign hit[g]  = running && (cnt == slot_q[g]);
    assign vals[g] = slot_q[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse <= '0;
      any   <= 1'b0;
    end else begin
      pulse <= hit;
      any   <= |hit;
    end
  end

endmodule

// File: rtl/split_timer.sv
module split_timer
  import split_timer_pkg::*;
#(
  parameter int          DW       = 32,
  parameter int          AW       = 8,
  parameter int          NCMP     = 8,
  parameter logic [31:0] ID_VALUE = 32'h5A17_0102
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_we,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic            irq_lo,
  output logic            irq_hi,
  output logic [NCMP-1:0] cmp_irq,
  output logic            cmp_any
);

  localparam int IW = (NCMP > 1) ? $clog2(NCMP) : 1;

  logic [3:0]               gctrl_q;
  logic [DW-1:0]            cnt_lo, cnt_hi, prd_lo, prd_hi;
  logic [1:0]               mode_lo, mode_hi;
  logic                     run_lo, run_hi;
  logic                     tm_ok;
  logic [NCMP-1:0][DW-1:0]  cmp_vals;
  logic [AW-1:0]            cmp_off;
  logic                     cmp_hit;
  logic [IW-1:0]            cmp_idx;
  logic [DW-1:0]            rd_mux;

  assign tm_ok   = (gctrl_q[3:2] == TMODE_SPLIT);
  assign cmp_off = bus_addr - AW'(OFS_CMP0);
  assign cmp_hit = (bus_addr >= AW'(OFS_CMP0)) && (cmp_off < AW'(4 * NCMP))
                   && (cmp_off[1:0] == 2'b00);
  assign cmp_idx = cmp_off[IW+1:2];

  always_ff @(posedge clk) begin
    if (rst) gctrl_q <= '0;
    else if (bus_we && bus_addr == AW'(OFS_GLOBAL)) gctrl_q <= bus_wdata[3:0];
  end

  split_timer_half #(.DW(DW)) u_lo (
    .clk        (clk),
    .rst        (rst),
    .rel        (gctrl_q[0]),
    .tm_ok      (tm_ok),
    .cnt_we     (bus_we && bus_addr == AW'(OFS_CNT_LO)),
    .prd_we     (bus_we && bus_addr == AW'(OFS_PRD_LO)),
    .mode_we    (bus_we && bus_addr == AW'(OFS_RUN)),
    .wdata      (bus_wdata),
    .mode_wdata (bus_wdata[LO_MODE_LSB+1:LO_MODE_LSB]),
    .cnt        (cnt_lo),
    .prd        (prd_lo),
    .mode       (mode_lo),
    .irq        (irq_lo),
    .running    (run_lo)
  );

  split_timer_half #(.DW(DW)) u_hi (
    .clk        (clk),
    .rst        (rst),
    .rel        (gctrl_q[1]),
    .tm_ok      (tm_ok),
    .cnt_we     (bus_we && bus_addr == AW'(OFS_CNT_HI)),
    .prd_we     (bus_we && bus_addr == AW'(OFS_PRD_HI)),
    .mode_we    (bus_we && bus_addr == AW'(OFS_RUN)),
    .wdata      (bus_wdata),
    .mode_wdata (bus_wdata[HI_MODE_LSB+1:HI_MODE_LSB]),
    .cnt        (cnt_hi),
    .prd        (prd_hi),
    .mode       (mode_hi),
    .irq        (irq_hi),
    .running    (run_hi)
  );

  split_timer_cmp #(.DW(DW), .N(NCMP), .IW(IW)) u_cmp (
    .clk     (clk),
    .rst     (rst),
    .we      (bus_we && cmp_hit),
    .idx     (cmp_idx),
    .wdata   (bus_wdata),
    .cnt     (cnt_lo),
    .running (run_lo),
    .vals    (cmp_vals),
    .pulse   (cmp_irq),
    .any     (cmp_any)
  );

  always_comb begin
    rd_mux = '0;
    if (bus_addr == AW'(OFS_ID)) rd_mux = DW'(ID_VALUE);
    else if (bus_addr == AW'(OFS_CNT_LO)) rd_mux = cnt_lo;
    else if (bus_addr == AW'(OFS_CNT_HI)) rd_mux = cnt_hi;
    else if (bus_addr == AW'(OFS_PRD_LO)) rd_mux = prd_lo;
    else if (bus_addr == AW'(OFS_PRD_HI)) rd_mux = prd_hi;
    else if (bus_addr == AW'(OFS_RUN)) begin
      rd_mux[LO_MODE_LSB+1:LO_MODE_LSB] = mode_lo;
      rd_mux[HI_MODE_LSB+1:HI_MODE_LSB] = mode_hi;
    end
    else if (bus_addr == AW'(OFS_GLOBAL)) rd_mux[3:0] = gctrl_q;
    else if (cmp_hit) rd_mux = cmp_vals[cmp_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end

endmodule

// File: rtl/split_timer_chk.sv
module split_timer_chk
  import split_timer_pkg::*;
#(
  parameter int DW   = 32,
  parameter int AW   = 8,
  parameter int NCMP = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            bus_we,
  input logic [AW-1:0]   bus_addr,
  input logic [3:0]      gctrl,
  input logic [DW-1:0]   cnt_lo,
  input logic [1:0]      mode_hi,
  input logic            run_lo,
  input logic            run_hi,
  input logic            irq_lo,
  input logic            irq_hi,
  input logic [NCMP-1:0] cmp_irq,
  input logic            cmp_any
);

  logic wr_cnt_lo, wr_run;
  assign wr_cnt_lo = bus_we && bus_addr == AW'(OFS_CNT_LO);
  assign wr_run    = bus_we && bus_addr == AW'(OFS_RUN);

  AST_FROZEN_OUTSIDE_SPLIT: assert property (@(posedge clk) disable iff (rst)
    (gctrl[0] && gctrl[3:2] != TMODE_SPLIT && !wr_cnt_lo) |=> $stable(cnt_lo)); // R3

  AST_HELD_WHILE_UNRELEASED: assert property (@(posedge clk) disable iff (rst)
    !gctrl[0] |=> (cnt_lo == '0)); // R4

  AST_PULSE_RESTARTS_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    irq_lo |-> (cnt_lo == '0)); // R5

  AST_HI_PULSE_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
    irq_hi |-> $past(run_hi)); // R5

  AST_SINGLE_SHOT_DISARMS: assert property (@(posedge clk) disable iff (rst)
    (irq_hi && $past(mode_hi) == 2'd1 && !$past(wr_run)) |-> (mode_hi == 2'd0)); // R6

  AST_CMP_ONLY_WHILE_RUNNING: assert property (@(posedge clk) disable iff (rst)
    (|cmp_irq) |-> $past(run_lo)); // R9

  AST_CMP_ANY_MATCHES: assert property (@(posedge clk) disable iff (rst)
    cmp_any == (|cmp_irq)); // R11

endmodule

bind split_timer split_timer_chk #(.DW(DW), .AW(AW), .NCMP(NCMP)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .gctrl    (gctrl_q),
  .cnt_lo   (cnt_lo),
  .mode_hi  (mode_hi),
  .run_lo   (run_lo),
  .run_hi   (run_hi),
  .irq_lo   (irq_lo),
  .irq_hi   (irq_hi),
  .cmp_irq  (cmp_irq),
  .cmp_any  (cmp_any)
);

// File: tb/tb_split_timer.sv
`timescale 1ns/1ps
module tb_split_timer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_lo, irq_hi, cmp_any;
  logic [7:0]  cmp_irq;

  int n_chk = 0;
  int n_bad = 0;

  localparam logic [31:0] EXP_ID = 32'hC0DE_7132;

  always #2.5 clk = ~clk;

  split_timer #(.ID_VALUE(EXP_ID)) dut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_lo(irq_lo),
    .irq_hi(irq_hi), .cmp_irq(cmp_irq), .cmp_any(cmp_any)
  );

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  function automatic logic pick(input int sel);
    case (sel)
      0: return irq_lo;
      1: return irq_hi;
      2: return cmp_any;
      default: return cmp_irq[sel-3];
    endcase
  endfunction

  task automatic measure(input int sel, input int maxk, output int k);
    k = 0;
    for (int i = 1; i <= maxk; i++) begin
      @(negedge clk);
      if (pick(sel)) begin k = i; break; end
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 reset irq_lo", {31'b0, irq_lo}, 32'd0);
    chk("R1 reset cmp_irq", {24'b0, cmp_irq}, 32'd0);
    rd(8'h00, d); chk("R1 id word", d, EXP_ID);
    rd(8'h18, d); chk("R1 reset low period", d, 32'hFFFF_FFFF);
    rd(8'h10, d); chk("R1 reset low count", d, 32'd0);
    rd(8'h24, d); chk("R1 reset global", d, 32'd0);
  endtask

  task automatic t_map();
    logic [31:0] d;
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h20, d); chk("R2 run field positions", d, 32'h00C0_00C0);
    wr(8'h24, 32'h7);
    rd(8'h24, d); chk("R1 global readback", d, 32'h7);
    repeat (5) @(negedge clk);
    rd(8'h10, d); chk("R12 code 3 low frozen", d, 32'd0);
    rd(8'h14, d); chk("R12 code 3 high frozen", d, 32'd0);
    wr(8'h20, 32'h0);
    wr(8'h28, 32'h1234);
    rd(8'h28, d); chk("R1 watchdog reads zero", d, 32'd0);
    rd(8'h40, d); chk("R1 unmapped reads zero", d, 32'd0);
    wr(8'h1C, 32'hA5A5);
    rd(8'h1C, d); chk("R1 high period readback", d, 32'hA5A5);
    rd(8'h1D, d); chk("R1 unaligned reads zero", d, 32'd0);
  endtask

  task automatic t_write_now();
    logic [31:0] d;
    wr(8'h10, 32'h1234);
    rd(8'h10, d); chk("R8 count write immediate", d, 32'h1234);
  endtask

  task automatic t_tmode();
    logic [31:0] d;
    wr(8'h10, 32'd100);
    wr(8'h24, 32'h3);
    wr(8'h20, 32'h80);
    repeat (10) @(negedge clk);
    rd(8'h10, d); chk("R3 mode 0 freezes", d, 32'd100);
    wr(8'h24, 32'hB);
    repeat (6) @(negedge clk);
    rd(8'h10, d); chk("R3 mode 2 freezes", d, 32'd100);
    wr(8'h20, 32'h0);
    wr(8'h24, 32'h7);
  endtask

  task automatic t_release();
    logic [31:0] d;
    wr(8'h10, 32'd55);
    wr(8'h24, 32'h6);
    @(negedge clk);
    rd(8'h10, d); chk("R4 held at zero", d, 32'd0);
    wr(8'h10, 32'd77);
    rd(8'h10, d); chk("R4 write ignored in reset", d, 32'd0);
    wr(8'h24, 32'h7);
  endtask

  task automatic t_periodic();
    int k;
    wr(8'h10, 32'd0);
    wr(8'h18, 32'd5);
    wr(8'h20, 32'h80);
    measure(0, 20, k); chk("R5 first pulse edges", k, 32'd6);
    measure(0, 20, k); chk("R5 repeat pulse edges", k, 32'd6);
    @(negedge clk);
    chk("R5 pulse one cycle", {31'b0, irq_lo}, 32'd0);
    wr(8'h20, 32'h0);
  endtask

  task automatic t_oneshot();
    int k;
    logic [31:0] d;
    wr(8'h14, 32'd0);
    wr(8'h1C, 32'd3);
    wr(8'h20, 32'h0040_0000);
    measure(1, 20, k); chk("R6 single pulse edges", k, 32'd4);
    rd(8'h20, d); chk("R6 mode cleared", d, 32'd0);
    measure(1, 12, k); chk("R6 no second pulse", k, 32'd0);
    rd(8'h14, d); chk("R6 count rests at zero", d, 32'd0);
  endtask

  task automatic t_compare();
    int k;
    logic [31:0] d;
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h10, 32'd10);
    for (int i = 0; i < 8; i++) wr(8'h60 + 8'(4 * i), 32'h8000_0000 + 32'(i));
    wr(8'h68, 32'd10 + 32'd7);
    wr(8'h74, 32'd20);
    rd(8'h74, d); chk("R1 compare slot readback", d, 32'd20);
    wr(8'h20, 32'h80);
    measure(2, 30, k); chk("R11 any with slot 2", k, 32'd8);
    chk("R9 slot 2 alone", {24'b0, cmp_irq}, 32'h04);
    measure(2, 30, k); chk("R11 any with slot 5", k, 32'd3);
    chk("R9 slot 5 alone", {24'b0, cmp_irq}, 32'h20);
    @(negedge clk);
    chk("R9 one clock pulse", {24'b0, cmp_irq}, 32'h0);
    chk("R11 any drops", {31'b0, cmp_any}, 32'd0);
    wr(8'h20, 32'h0);
  endtask

  task automatic t_cmp_wrap();
    int k;
    logic [31:0] base;
    base = 32'hFFFF_FFFE;
    wr(8'h10, base);
    wr(8'h60, base + 32'd3);
    wr(8'h20, 32'h80);
    measure(3, 20, k); chk("R10 wrapped compare edges", k, 32'd4);
    wr(8'h20, 32'h0);
  endtask

  task automatic t_wrap();
    int k;
    logic [31:0] d;
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h10, 32'hFFFF_FFFD);
    wr(8'h20, 32'h80);
    measure(0, 20, k); chk("R7 wrap pulse edges", k, 32'd3);
    rd(8'h10, d); chk("R7 count wrapped to zero", d, 32'd0);
    wr(8'h20, 32'h0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_map();
    t_write_now();
    t_tmode();
    t_release();
    t_periodic();
    t_oneshot();
    t_compare();
    t_cmp_wrap();
    t_wrap();
    repeat (2) @(negedge clk);
    report();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

endmodule